// File: doc/BRIEF.md
# Serial Configuration EEPROM Word Reader

This block reads one 16-bit word from a three-wire serial configuration EEPROM of the select/clock/data-in/data-out kind. The host places a 6-bit word address on `rd_addr` and pulses `start` for one cycle. The block then runs the whole frame on its own. It raises chip select and shifts out a 3-bit read command and the address. It drives its data-in line low, clocks in sixteen data bits, and releases chip select. It then gives one more clock pulse with the part deselected. At the end it presents the word on `rd_data` with a one-cycle `done` pulse.

All serial timing is counted in system clock cycles. `SETUP_CYC` sets how long a data bit is held before the serial clock rises. `PHASE_CYC` sets the length of each serial clock phase. For a 50 MHz system clock, values of 20 and 450 give 0.4 µs and 9 µs. While a frame is running the block takes no notice of `start`.

Top module: `eeprom_word_reader`

## Requirements
- R1: Chip select rises while the serial clock is low, before the first clock rise. It stays high through all 25 clock rises of the frame (9 command/address bits plus 16 data bits) and falls only after the last of them.
- R2: The outgoing bits are the read command 3'b110 followed by the 6-bit address, each sent MSB first. The EEPROM captures each bit on a rising serial clock edge.
- R3: Each outgoing bit is on the data-in line for `SETUP_CYC` system cycles before the serial clock rises. It does not change on the cycle of that rise.
- R4: After the last address bit, data-in goes low and stays low for at least `SETUP_CYC` cycles before the first readback clock rise. It stays low for all 16 readback bits.
- R5: The block reads exactly 16 data bits, MSB first. It samples each bit during the last system cycle of a serial clock high phase, and the assembled word appears on `rd_data`.
- R6: Every serial clock high phase lasts exactly `PHASE_CYC` cycles. Every low phase lasts at least `PHASE_CYC` cycles.
- R7: After the 16th data bit, chip select and data-in are both low. Then one further serial clock pulse, high then low, is issued while the part is deselected.
- R8: `done` is high for exactly one cycle, after the low phase of the trailing pulse. `rd_data` holds the word from that point until the next `done`. `done` is never high while a frame is active.
- R9: A frame begins only from a `start` seen while idle. A `start` during a frame has no effect: no second frame follows, and the result is the word for the first address.
- R10: After reset, chip select, serial clock, data-in and `done` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read a word |
| rd_addr | input | 6 | Word address to read |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_data | output | 16 | Last word read |
| done | output | 1 | One-cycle pulse when `rd_data` is valid |

## Verification
The bench sweeps every address from 0 to 63 against a modelled EEPROM whose contents come from an arithmetic hash of the address. A wrong address bit, a mis-ordered command, or data shifted by one position each gives a different word. The run repeats with all-zero, all-ones and alternating contents. These patterns show whether the block really samples the data line or only holds a stale or constant level, and they expose a bit-order swap at the word's ends. A second `start` in the middle of a frame tests whether the request is ignored. At every clock edge the EEPROM model measures setup and phase lengths, so every read also checks R3, R4 and R6.

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int SETUP_CYC = 20,
  parameter int PHASE_CYC = 450
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  rd_addr,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic [15:0] rd_data,
  output logic        done
);
  localparam int MAXC = (PHASE_CYC > SETUP_CYC) ? PHASE_CYC : SETUP_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PH_LD = CW'(PHASE_CYC - 1);
  localparam logic [CW-1:0] SU_LD = CW'(SETUP_CYC - 1);
  localparam logic [2:0] RD_CMD = 3'b110;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_OHI, S_OLO, S_HOLD, S_RHI, S_RLO, S_DESEL, S_THI, S_TLO
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] bits;
  logic [15:0] shreg;

  assign ee_sk = st inside {S_OHI, S_RHI, S_THI};
  assign ee_cs = st inside {S_SETUP, S_OHI, S_OLO, S_HOLD, S_RHI, S_RLO};
  assign ee_di = (st inside {S_SETUP, S_OHI, S_OLO}) & shreg[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bits    <= '0;
      shreg   <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          shreg <= {RD_CMD, rd_addr, 7'b0};
          bits  <= 4'd8;
          cnt   <= SU_LD;
          st    <= S_SETUP;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_SETUP: begin st <= S_OHI; cnt <= PH_LD; end
          S_OHI:   begin st <= S_OLO; cnt <= PH_LD; end
          S_OLO: begin
            if (bits == '0) begin
              st   <= S_HOLD;
              bits <= 4'd15;
            end else begin
              st    <= S_SETUP;
              shreg <= {shreg[14:0], 1'b0};
              bits  <= bits - 1'b1;
            end
            cnt <= SU_LD;
          end
          S_HOLD:  begin st <= S_RHI; cnt <= PH_LD; end
          S_RHI: begin
            shreg <= {shreg[14:0], ee_do};
            st    <= S_RLO;
            cnt   <= PH_LD;
          end
          S_RLO: begin
            if (bits == '0) st <= S_DESEL;
            else begin
              st   <= S_RHI;
              bits <= bits - 1'b1;
            end
            cnt <= PH_LD;
          end
          S_DESEL: begin st <= S_THI; cnt <= PH_LD; end
          S_THI:   begin st <= S_TLO; cnt <= PH_LD; end
          S_TLO: begin
            st      <= S_IDLE;
            rd_data <= shreg;
            done    <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_word_reader_chk.sv
module eeprom_word_reader_chk #(
  parameter int PHASE_CYC = 450
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic done
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else hi_cnt <= ee_sk ? hi_cnt + 1 : '0;
  end

  AST_CS_RISES_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> !ee_sk); // R1
  AST_DI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_sk) |-> $stable(ee_di)); // R3
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_sk) |-> hi_cnt == 32'(PHASE_CYC)); // R6
  AST_DI_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) !ee_cs |-> !ee_di); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ee_cs && !ee_sk); // R8
  AST_FRAME_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> $past(start)); // R9
endmodule

bind eeprom_word_reader eeprom_word_reader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ee_cs(ee_cs),
  .ee_sk(ee_sk), .ee_di(ee_di), .done(done)
);

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;
  localparam int SU = 2;
  localparam int PH = 3;

  logic clk = 0, rst_n = 0, start = 0, ee_do = 0;
  logic [5:0] rd_addr = '0;
  logic ee_cs, ee_sk, ee_di, done;
  logic [15:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  int pat = 0, frames = 0, rises = 0, trail = 0, di_run = 0, sk_run = 0;
  logic [8:0] cmd = '0;
  logic [15:0] cur = '0;
  logic p_sk = 0, p_cs = 0, p_di = 0;

  always #10 clk = ~clk;

  eeprom_word_reader #(.SETUP_CYC(SU), .PHASE_CYC(PH)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int a, input int p);
    case (p)
      1: word_of = 16'h0000;
      2: word_of = 16'hFFFF;
      3: word_of = a[0] ? 16'hAAAA : 16'h5555;
      default: word_of = 16'(a * 40503) ^ 16'h5AC3;
    endcase
  endfunction

  // EEPROM model and timing monitor
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (ee_di == p_di) di_run++; else di_run = 1;
      if (ee_sk != p_sk) begin
        if (p_sk) chk(sk_run == PH, "R6 high phase", sk_run, PH);
        else chk(sk_run >= PH, "R6 low phase", sk_run, PH);
        sk_run = 1;
      end else sk_run++;
      if (ee_cs && !p_cs) begin
        frames++; rises = 0; trail = 0; cmd = '0;
        chk(!ee_sk, "R1 select before clock", ee_sk, 0);
      end
      if (ee_sk && !p_sk) begin
        if (ee_cs) begin
          rises++;
          chk(di_run >= SU + 1, "R3 setup", di_run, SU + 1);
          if (rises <= 9) cmd = {cmd[7:0], ee_di};
          else begin
            chk(!ee_di, "R4 data-in low", ee_di, 0);
            if (rises == 10) cur = word_of(int'(cmd[5:0]), pat);
            if (rises <= 25) ee_do <= cur[25 - rises];
          end
        end else trail++;
      end
      if (!ee_cs && p_cs) begin
        chk(rises == 25, "R1 rises in frame", rises, 25);
        chk(!ee_di && !ee_sk, "R7 deselect", {ee_di, ee_sk}, 0);
        ee_do <= 1'b0;
      end
    end
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8 done seen", done, 1);
  endtask

  task automatic pulse_start(input int a);
    rd_addr = 6'(a);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_read(input int a);
    logic [15:0] exp;
    exp = word_of(a, pat);
    pulse_start(a);
    wait_done();
    chk(cmd[8:6] == 3'b110, "R2 command", cmd[8:6], 3'b110);
    chk(cmd[5:0] == 6'(a), "R2 address", cmd[5:0], a);
    chk(rd_data == exp, "R5 word", rd_data, exp);
    chk(trail == 1, "R7 trailing pulse", trail, 1);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, done} == 4'b0, "R10 reset outputs", {ee_cs, ee_sk, ee_di, done}, 0);
    chk(rd_data == 16'h0, "R10 reset data", rd_data, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    for (int a = 0; a < 64; a++) do_read(a);
    for (int p = 1; p < 4; p++) begin
      pat = p;
      do_read(0); do_read(63); do_read(21); do_read(42);
    end
    // R9: request during a frame is ignored
    pat = 0;
    begin
      int f0;
      logic [15:0] hold;
      f0 = frames;
      pulse_start(5);
      repeat (40) @(negedge clk);
      pulse_start(40);
      wait_done();
      chk(rd_data == word_of(5, 0), "R9 first address kept", rd_data, word_of(5, 0));
      hold = rd_data;
      repeat (300) @(negedge clk);
      chk(frames == f0 + 1, "R9 no second frame", frames, f0 + 1);
      chk(rd_data == hold, "R8 data held", rd_data, hold);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule